// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous cache memory, 32 bits wide, whose reads flow straight from the array to the output with no output register. On each rising clock edge it captures the address, the three chip enables and the write controls. A burst can be opened by either of two address strobes. One comes from the processor side and is qualified by the first chip enable. The other comes from the cache controller side and always samples all three enables. A 2-bit counter on the two low address bits then walks the remaining three words of the aligned group of four. The walk is linear or interleaved, chosen by a mode pin, and it steps only on edges where the advance input is low.

Writes are per byte lane and self-timed from the clock edge. A global write strobe writes the whole word. A byte-write enable together with four lane strobes writes single bytes. The output drive is reported on a separate enable flag, so the data bus appears as separate input and output ports. That flag follows the output-enable pin without a clock. A sleep input freezes every register, blocks writes and turns the drive flag off, and it keeps the memory contents. The word count is set by the parameter `ADDR_W`: 17 gives the full 128K-word part, and the default of 10 keeps elaboration small.

Top module: `fts_sram`

## Requirements
- R1: After reset the device is deselected: `q_oe_o` is 0 even with `oe_n_i` low, until a burst is opened with the device selected.
- R2: A burst start selects the device only if `ce1_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0 at that edge. Any other combination deselects it: `q_oe_o` goes to 0 and no write takes place.
- R3: A low `adsp_n_i` is ignored while `ce1_n_i` is 1. With `adsc_n_i` high, the open burst keeps its address and its selection.
- R4: With `mode_i`=0, burst step k (0..3) accesses low address bits (s+k) mod 4, where s is the low two bits captured at the start. The fifth access wraps to s.
- R5: With `mode_i`=1, burst step k accesses low address bits s XOR k.
- R6: On an edge with no strobe start and `adv_n_i`=1, the burst address is held.
- R7: Reads are flow-through. Array data for the address registered at an edge appears on `q_o` within that same clock cycle.
- R8: `gw_n_i`=0 writes all four bytes of the current burst address at the edge.
- R9: With `gw_n_i`=1 and `bwe_n_i`=0, only the lanes whose `bw_n_i` bit is 0 are written. Bit i covers data bits 8i+7:8i. With both `gw_n_i` and `bwe_n_i` high, nothing is written.
- R10: An edge that starts a burst through `adsp_n_i` never writes; writes follow on later edges. An edge that starts a burst through `adsc_n_i` applies its write controls at the new address.
- R11: `oe_n_i`=1 forces `q_oe_o` to 0 in the same cycle, without waiting for a clock edge.
- R12: While `zz_i`=1, `q_oe_o` is 0, no write occurs and the address, counter and selection are frozen. Operation resumes from the same state on the first edge after `zz_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, captured at a burst start |
| adsp_n_i | input | 1 | Processor-side address strobe, active low |
| adsc_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce1_n_i | input | 1 | Chip enable 1, active low; also qualifies `adsp_n_i` |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_n_i | input | 1 | Chip enable 3, active low |
| gw_n_i | input | 1 | Global write, all lanes, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bw_n_i | input | 4 | Per-lane write strobes, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| zz_i | input | 1 | Sleep request, active high |
| mode_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| d_i | input | 32 | Write data |
| q_o | output | 32 | Flow-through read data |
| q_oe_o | output | 1 | Output drive flag |

## Verification
A wrong counter or base register appears on `q_o` in the very cycle after the faulty edge, because reads have no pipeline stage. Every burst step in both orders is therefore compared on the cycle it is taken. A bad write lane or a write that should not have happened shows up the next time that word is read. The bench reads back each touched word soon after, including on edges where a write would have changed the flow-through data at once. A wrong selection or sleep state shows on `q_oe_o` in the same cycle.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // order of the 2-bit burst walk, driven by the mode pin
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} burst_ord_e;

  function automatic logic [1:0] burst_lo(input logic [1:0] s, input logic [1:0] k,
                                          input burst_ord_e ord);
    return (ord == ORD_XOR) ? (s ^ k) : (s + k);
  endfunction
endpackage

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr
  import fts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_i,
  input  logic [1:0] ld_lo_i,
  input  logic       step_i,
  input  logic       ord_i,
  output logic [1:0] lo_o,
  output logic [1:0] lo_nx_o
);
  logic [1:0] seed_q, seed_d;
  logic [1:0] off_q, off_d;
  burst_ord_e ord;

  assign ord = burst_ord_e'(ord_i);

  always_comb begin
    seed_d = seed_q;
    off_d  = off_q;
    if (ld_i) begin
      seed_d = ld_lo_i;
      off_d  = 2'd0;
    end else if (step_i) begin
      off_d = off_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= 2'd0;
      off_q  <= 2'd0;
    end else begin
      seed_q <= seed_d;
      off_q  <= off_d;
    end
  end

  assign lo_o    = burst_lo(seed_q, off_q, ord);
  assign lo_nx_o = burst_lo(seed_d, off_d, ord);

  // R4
  ctr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q == 2'd3 && step_i && !ld_i) |=> (off_q == 2'd0 && seed_q == $past(seed_q)));

  // R6
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !step_i) |=> (off_q == $past(off_q) && seed_q == $past(seed_q)));
endmodule

// File: rtl/fts_byte_lane.sv
module fts_byte_lane #(
  parameter int AW = 10,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  d_i,
  input  logic [AW-1:0] ra_i,
  output logic [W-1:0]  q_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= d_i;
  end

  assign q_o = mem[ra_i];
endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_n_i,
  input  logic              adsc_n_i,
  input  logic              adv_n_i,
  input  logic              ce1_n_i,
  input  logic              ce2_i,
  input  logic              ce3_n_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [LANES-1:0]  bw_n_i,
  input  logic              oe_n_i,
  input  logic              zz_i,
  input  logic              mode_i,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] q_o,
  output logic              q_oe_o
);
  localparam int BASE_W = ADDR_W - 2;

  logic              sel, p_start, start, step, wr_ok;
  logic              act_q, act_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [1:0]        lo_cur, lo_nx;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [LANES-1:0]  lane_we;

  // strobe qualification and burst control
  always_comb begin
    sel     = !ce1_n_i && ce2_i && !ce3_n_i;
    p_start = !adsp_n_i && !ce1_n_i;
    start   = !zz_i && (p_start || !adsc_n_i);
    step    = !zz_i && !start && act_q && !adv_n_i;
    act_d   = start ? sel : act_q;
    base_d  = start ? addr_i[ADDR_W-1:2] : base_q;
    wr_ok   = !zz_i && ((start && !p_start && sel) || (!start && act_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
    end
  end

  fts_burst_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_i    (start),
    .ld_lo_i (addr_i[1:0]),
    .step_i  (step),
    .ord_i   (mode_i),
    .lo_o    (lo_cur),
    .lo_nx_o (lo_nx)
  );

  assign rd_addr = {base_q, lo_cur};
  assign wr_addr = {base_d, lo_nx};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = wr_ok && (!gw_n_i || (!bwe_n_i && !bw_n_i[i]));

    fts_byte_lane #(.AW(ADDR_W), .W(LANE_W)) u_lane (
      .clk  (clk),
      .we_i (lane_we[i]),
      .wa_i (wr_addr),
      .d_i  (d_i[i*LANE_W +: LANE_W]),
      .ra_i (rd_addr),
      .q_o  (q_o[i*LANE_W +: LANE_W])
    );
  end

  assign q_oe_o = act_q && !oe_n_i && !zz_i;

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !q_oe_o);

  // R12
  zz_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zz_i |=> (act_q == $past(act_q) && base_q == $past(base_q) && !$past(|lane_we)));

  // R2
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz_i && !adsc_n_i && (ce1_n_i || !ce2_i || ce3_n_i)) |=> !q_oe_o);

  // R3
  adsp_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz_i && !adsp_n_i && ce1_n_i && adsc_n_i) |=>
      (base_q == $past(base_q) && act_q == $past(act_q)));

  // R10
  adsp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n_i && !ce1_n_i) |-> (lane_we == '0));
endmodule

// File: tb/sim_fts_sram.sv
module sim_fts_sram;
  localparam int AW = 10;

  typedef struct {
    bit          chk;
    bit          oe;
    logic [31:0] q;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n, zz, mode;
  logic [3:0]    bw_n;
  logic [31:0]   d, q;
  logic          q_oe;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  fts_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .adsp_n_i(adsp_n), .adsc_n_i(adsc_n),
    .adv_n_i(adv_n), .ce1_n_i(ce1_n), .ce2_i(ce2), .ce3_n_i(ce3_n), .gw_n_i(gw_n),
    .bwe_n_i(bwe_n), .bw_n_i(bw_n), .oe_n_i(oe_n), .zz_i(zz), .mode_i(mode),
    .d_i(d), .q_o(q), .q_oe_o(q_oe)
  );

  // monitor: one queued item per clock cycle, sampled after the edge settles
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (e.chk) begin
        n_run++;
        if (q_oe !== e.oe) begin
          n_fail++;
          $display("FAIL %s: q_oe_o=%b expected %b", e.tag, q_oe, e.oe);
        end else if (e.oe && q !== e.q) begin
          n_fail++;
          $display("FAIL %s: q_o=%h expected %h", e.tag, q, e.q);
        end
      end
    end
  end

  // start a cycle: wait for the falling edge and return controls to idle
  task automatic tick();
    @(negedge clk);
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hf;
  endtask

  task automatic expect_out(bit chk, bit oe, logic [31:0] val, string tag);
    exp_t e;
    e.chk = chk; e.oe = oe; e.q = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; d = '0;
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hf;
    oe_n = 1'b0; zz = 1'b0; mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tick(); expect_out(1, 0, '0, "R1 reset deselected");

    // ADSC-started full-word write burst at 0x040, linear (R8, R10)
    tick(); adsc_n = 0; addr = 10'h040; gw_n = 0; d = 32'h11111111; expect_out(0, 0, '0, "");
    tick(); adv_n = 0; gw_n = 0; d = 32'h22222222; expect_out(0, 0, '0, "");
    tick(); adv_n = 0; gw_n = 0; d = 32'h33333333; expect_out(0, 0, '0, "");
    tick(); adv_n = 0; gw_n = 0; d = 32'h44444444; expect_out(0, 0, '0, "");
    tick(); adsc_n = 0; addr = 10'h044; gw_n = 0; d = 32'h55555555; expect_out(0, 0, '0, "");

    // linear read from low bits 1 (R4, R7, R10)
    tick(); adsp_n = 0; addr = 10'h041; expect_out(1, 1, 32'h22222222, "R7 flow-through first word");
    tick(); adv_n = 0; expect_out(1, 1, 32'h33333333, "R4 linear step1");
    tick(); adv_n = 0; expect_out(1, 1, 32'h44444444, "R4 linear step2");
    tick(); adv_n = 0; expect_out(1, 1, 32'h11111111, "R4 linear wrap");
    tick(); adv_n = 0; expect_out(1, 1, 32'h22222222, "R4 linear fifth access");

    // interleaved read from low bits 2 (R5)
    tick(); mode = 1; adsc_n = 0; addr = 10'h042; expect_out(1, 1, 32'h33333333, "R5 xor step0");
    tick(); adv_n = 0; expect_out(1, 1, 32'h44444444, "R5 xor step1");
    tick(); adv_n = 0; expect_out(1, 1, 32'h11111111, "R5 xor step2");
    tick(); adv_n = 0; expect_out(1, 1, 32'h22222222, "R5 xor step3");
    tick(); expect_out(1, 1, 32'h22222222, "R6 hold without advance");

    // byte-lane write: lanes 0 and 2 (R9)
    tick(); adsc_n = 0; addr = 10'h040; bwe_n = 0; bw_n = 4'b1010; d = 32'hAAAAAAAA;
    expect_out(0, 0, '0, "");
    tick(); expect_out(1, 1, 32'h11AA11AA, "R9 selected lanes only");
    tick(); bw_n = 4'h0; d = 32'hFFFFFFFF; expect_out(1, 1, 32'h11AA11AA, "R9 no write without enable");

    // ADSP start never writes (R10)
    tick(); adsp_n = 0; addr = 10'h044; gw_n = 0; d = 32'hDEADBEEF;
    expect_out(1, 1, 32'h55555555, "R10 adsp start edge no write");
    tick(); gw_n = 0; d = 32'h66666666; expect_out(1, 1, 32'h66666666, "R10 write on following edge");
    tick(); expect_out(1, 1, 32'h66666666, "R8 word kept");

    // chip-enable decode (R2)
    tick(); adsc_n = 0; addr = 10'h040; ce2 = 0; gw_n = 0; d = 32'h0;
    expect_out(1, 0, '0, "R2 ce2 low deselects");
    tick(); ce2 = 1; ce3_n = 1; adsc_n = 0; addr = 10'h040; expect_out(1, 0, '0, "R2 ce3 high deselects");
    tick(); ce3_n = 0; adsc_n = 0; addr = 10'h040;
    expect_out(1, 1, 32'h11AA11AA, "R2 reselect, deselected write ignored");

    // ADSP ignored while ce1 high (R3)
    tick(); ce1_n = 1; adsp_n = 0; addr = 10'h044; expect_out(1, 1, 32'h11AA11AA, "R3 adsp ignored");
    tick(); ce1_n = 0; expect_out(1, 1, 32'h11AA11AA, "R3 burst unchanged");

    // output enable (R11)
    tick(); oe_n = 1; expect_out(1, 0, '0, "R11 oe high");
    tick(); oe_n = 0; expect_out(1, 1, 32'h11AA11AA, "R11 oe low again");

    // sleep (R12)
    tick(); zz = 1; adsc_n = 0; gw_n = 0; addr = 10'h044; d = 32'h0; expect_out(1, 0, '0, "R12 sleep drive off");
    tick(); zz = 1; adv_n = 0; expect_out(1, 0, '0, "R12 sleep no advance");
    tick(); zz = 0; expect_out(1, 1, 32'h11AA11AA, "R12 resume same state");
    tick(); adsp_n = 0; addr = 10'h044; expect_out(1, 1, 32'h66666666, "R12 contents kept");

    tick(); expect_out(0, 0, '0, "");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule